// File: doc/BRIEF.md
# PoE Powered-Device Power Sequencer

This block is the digital controller for the isolation switch of a Power-over-Ethernet powered device. Five comparator flags come in: input above the turn-on level, input below the turn-off level, return node high, switch fully enhanced, and over-temperature. From them it drives the switch enable, a 2-bit code that picks the analog current limit, and a request to pull the power-good line low so that the downstream converter stays disabled.

When the input rises past the turn-on level, the switch closes at an inrush limit. While the return node is still high during inrush, the code selects a lower foldback limit. Once the switch reports full enhancement, the code moves to the normal limit. Power-good stays held low until a minimum delay has run from inrush entry. An under-voltage exit only takes effect after the input has stayed below the turn-off level for a deglitch time. An over-temperature event opens the switch. When the temperature flag clears, the whole inrush sequence runs again.

All timing counts prescaled ticks. Every flag passes through a two-flop synchroniser.

Top module: `pd_pwr_seq`

## Requirements
- R1: Reset leaves the block off: `sw_en`=0, `ilim_sel`=00 and `pg_pull_low`=1. The limit code is 00 off, 01 inrush, 10 normal, 11 foldback.
- R2: In power mode, only an input held below the turn-off level for `DEGLITCH_TICKS` ticks opens the switch. A shorter dip, or an input that sits between the two thresholds, leaves power mode untouched.
- R3: In the inrush state `sw_en`=1 and `pg_pull_low`=1. `ilim_sel` is 11 while the return-node flag is set and 01 otherwise.
- R4: After the enhanced flag is seen, `ilim_sel` is 10. It changes to 11 whenever the return-node flag is set.
- R5: `pg_pull_low` stays 1 until at least `PG_TICKS` ticks have passed since inrush entry and the switch is enhanced, whichever is later. It then falls to 0.
- R6: While the synchronised over-temperature flag is set, the switch opens on the next cycle: `sw_en`=0, `ilim_sel`=00 and `pg_pull_low`=1.
- R7: When over-temperature clears with the input still valid, the block re-enters inrush. The power-good delay restarts from zero.
- R8: The block leaves the off state only when the input is above turn-on and no over-temperature is flagged. If the deglitch time runs out during thermal shutdown, the block returns to off once the temperature clears.
- R9: A change on any flag input reaches the state, and so the outputs, on the third rising clock edge after it is driven. The return-node effect on `ilim_sel` appears on the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_above_on | input | 1 | Input is above the turn-on level |
| vin_below_off | input | 1 | Input is below the turn-off level |
| rtn_high | input | 1 | Return node is far above the negative rail |
| sw_enhanced | input | 1 | Isolation switch is fully enhanced |
| over_temp | input | 1 | Junction over-temperature |
| sw_en | output | 1 | Isolation switch enable |
| ilim_sel | output | 2 | Current-limit select code |
| pg_pull_low | output | 1 | Request to hold power-good low |

## Verification
The embedded assertions check several rules on every cycle:
- the switch opens only after a deglitch expiry or an over-temperature flag;
- an over-temperature flag always opens the switch on the next cycle;
- the switch always closes with an inrush or foldback code, never the normal one;
- power-good is never released before the delay timer finishes;
- each inrush entry clears that timer.

Some behaviour only the bench scenarios can show:
- the exact deglitch boundary, where a dip one tick short is survived and a full-length dip is not;
- the hysteresis band;
- the power-good release window;
- the restart after thermal shutdown;
- the three-edge input latency.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

  // flag positions on the synchronised input bus
  localparam int F_ON    = 0;
  localparam int F_OFF   = 1;
  localparam int F_RTN   = 2;
  localparam int F_ENH   = 3;
  localparam int F_HOT   = 4;
  localparam int NFLAGS  = 5;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_INRUSH = 3'd1,
    ST_HOLD   = 3'd2,
    ST_POWER  = 3'd3,
    ST_HOT    = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    LIM_OFF    = 2'b00,
    LIM_INRUSH = 2'b01,
    LIM_NORMAL = 2'b10,
    LIM_FOLD   = 2'b11
  } lim_code_t;

  // limit code chosen from the state and the return-node flag
  function automatic lim_code_t pick_limit(seq_state_t st, logic rtn_hi);
    case (st)
      ST_INRUSH:         pick_limit = rtn_hi ? LIM_FOLD : LIM_INRUSH;
      ST_HOLD, ST_POWER: pick_limit = rtn_hi ? LIM_FOLD : LIM_NORMAL;
      default:           pick_limit = LIM_OFF;
    endcase
  endfunction

endpackage

// File: rtl/pd_seq_sync.sv
module pd_seq_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d_async[g];
        stab_q <= meta_q;
      end
    end
    assign q_sync[g] = stab_q;
  end

endmodule

// File: rtl/pd_seq_tick.sv
module pd_seq_tick #(
  parameter int PRESCALE = 250
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  if (PRESCALE <= 1) begin : g_every
    assign tick = 1'b1;
  end else begin : g_div
    localparam int PW = $clog2(PRESCALE);
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
    logic [PW-1:0] div_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            div_q <= '0;
      else if (div_q == LAST) div_q <= '0;
      else                   div_q <= div_q + 1'b1;
    end
    assign tick = (div_q == LAST);
  end

endmodule

// File: rtl/pd_seq_timer.sv
module pd_seq_timer #(
  parameter int LIMIT = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic done
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  // saturating tick counter step
  function automatic logic [CW-1:0] step(logic [CW-1:0] c, logic t);
    step = (t && c != TOP) ? c + 1'b1 : c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else            cnt_q <= step(cnt_q, tick);
  end

  assign done = (cnt_q == TOP);

endmodule

// File: rtl/pd_pwr_seq.sv
module pd_pwr_seq
  import pd_seq_pkg::*;
#(
  parameter int PRESCALE       = 250,
  parameter int DEGLITCH_TICKS = 75,
  parameter int PG_TICKS       = 96000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vin_above_on,
  input  logic       vin_below_off,
  input  logic       rtn_high,
  input  logic       sw_enhanced,
  input  logic       over_temp,
  output logic       sw_en,
  output logic [1:0] ilim_sel,
  output logic       pg_pull_low
);

  logic [NFLAGS-1:0] raw_flags, s_flags;
  logic tick, dg_done, pg_done, enter_inrush;
  logic on_s, below_s, rtn_s, enh_s, ot_s;
  seq_state_t state_q, state_d;

  assign raw_flags[F_ON]  = vin_above_on;
  assign raw_flags[F_OFF] = vin_below_off;
  assign raw_flags[F_RTN] = rtn_high;
  assign raw_flags[F_ENH] = sw_enhanced;
  assign raw_flags[F_HOT] = over_temp;

  pd_seq_sync #(.WIDTH(NFLAGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw_flags), .q_sync(s_flags)
  );

  assign on_s    = s_flags[F_ON];
  assign below_s = s_flags[F_OFF];
  assign rtn_s   = s_flags[F_RTN];
  assign enh_s   = s_flags[F_ENH];
  assign ot_s    = s_flags[F_HOT];

  pd_seq_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  // under-voltage deglitch: ticks counted while the input stays low
  pd_seq_timer #(.LIMIT(DEGLITCH_TICKS)) u_deglitch (
    .clk(clk), .rst_n(rst_n), .clear(!below_s), .tick(tick), .done(dg_done)
  );

  // power-good hold-off: restarted on every inrush entry
  pd_seq_timer #(.LIMIT(PG_TICKS)) u_pg_hold (
    .clk(clk), .rst_n(rst_n), .clear(enter_inrush), .tick(tick), .done(pg_done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_OFF:
        if (on_s && !ot_s) state_d = ST_INRUSH;
      ST_INRUSH, ST_HOLD, ST_POWER: begin
        if (dg_done)      state_d = ST_OFF;
        else if (ot_s)    state_d = ST_HOT;
        else if (state_q == ST_INRUSH && enh_s) state_d = ST_HOLD;
        else if (state_q == ST_HOLD && pg_done) state_d = ST_POWER;
      end
      ST_HOT:
        if (!ot_s) state_d = dg_done ? ST_OFF : ST_INRUSH;
      default: state_d = ST_OFF;
    endcase
  end

  assign enter_inrush = (state_d == ST_INRUSH) && (state_q != ST_INRUSH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign sw_en       = (state_q == ST_INRUSH) || (state_q == ST_HOLD) || (state_q == ST_POWER);
  assign ilim_sel    = pick_limit(state_q, rtn_s);
  assign pg_pull_low = (state_q != ST_POWER);

  // ---------------- assertions ----------------
  AST_EXIT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en) |-> $past(dg_done || ot_s)); // R2
  AST_CLOSE_AT_INRUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> (ilim_sel != 2'b10)); // R3
  AST_HOT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    ot_s |=> !sw_en); // R6
  AST_PG_WAITS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_done |-> pg_pull_low); // R5
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    enter_inrush |=> !pg_done); // R7

endmodule

// File: tb/pd_pwr_seq_test.sv
`timescale 1ns/1ps
module pd_pwr_seq_test;

  localparam int P = 4;
  localparam int D = 5;
  localparam int G = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vin_above_on = 1'b0, vin_below_off = 1'b1, rtn_high = 1'b0;
  logic sw_enhanced = 1'b0, over_temp = 1'b0;
  logic sw_en, pg_pull_low;
  logic [1:0] ilim_sel;

  always #2 clk = ~clk;

  pd_pwr_seq #(.PRESCALE(P), .DEGLITCH_TICKS(D), .PG_TICKS(G)) uut (
    .clk(clk), .rst_n(rst_n), .vin_above_on(vin_above_on), .vin_below_off(vin_below_off),
    .rtn_high(rtn_high), .sw_enhanced(sw_enhanced), .over_temp(over_temp),
    .sw_en(sw_en), .ilim_sel(ilim_sel), .pg_pull_low(pg_pull_low)
  );

  typedef struct {
    int unsigned at;
    logic        sw;
    logic [1:0]  lim;
    logic        pg;
    string       tag;
  } exp_t;

  exp_t sq[$];
  int unsigned cyc = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // driver side: schedule an expected output set at an absolute cycle
  task automatic expect_at(int unsigned at, logic sw, logic [1:0] lim, logic pg, string tag);
    exp_t e;
    e.at = at; e.sw = sw; e.lim = lim; e.pg = pg; e.tag = tag;
    sq.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: compares at the falling edge, away from the active edge
  always @(negedge clk) begin
    for (int i = sq.size() - 1; i >= 0; i--) begin
      if (sq[i].at == cyc) begin
        checks++;
        if (sw_en !== sq[i].sw || ilim_sel !== sq[i].lim || pg_pull_low !== sq[i].pg) begin
          errors++;
          $display("FAIL %s at cycle %0d: got sw=%b lim=%b pg=%b expected sw=%b lim=%b pg=%b",
                   sq[i].tag, cyc, sw_en, ilim_sel, pg_pull_low, sq[i].sw, sq[i].lim, sq[i].pg);
        end
        sq.delete(i);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned c;
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_at(cyc + 1, 1'b0, 2'b00, 1'b1, "R1 reset state");
    step(3);

    // power-up with return node high: foldback during inrush
    c = cyc;
    vin_above_on = 1'b1; vin_below_off = 1'b0; rtn_high = 1'b1;
    expect_at(c + 2, 1'b0, 2'b00, 1'b1, "R9 still off after two edges");
    expect_at(c + 3, 1'b1, 2'b11, 1'b1, "R3 inrush foldback / R9 latency");
    step(6);
    rtn_high = 1'b0;
    expect_at(cyc + 3, 1'b1, 2'b01, 1'b1, "R3 inrush level");
    step(4);
    sw_enhanced = 1'b1;
    expect_at(cyc + 3, 1'b1, 2'b10, 1'b1, "R4 normal after enhanced");
    expect_at(c + (G - 1) * P, 1'b1, 2'b10, 1'b1, "R5 power-good still held");
    expect_at(c + G * P + 8, 1'b1, 2'b10, 1'b0, "R5 power-good released");
    step(c + G * P + 10 - cyc);

    rtn_high = 1'b1;
    expect_at(cyc + 3, 1'b1, 2'b11, 1'b0, "R4 foldback in power mode");
    step(4);
    rtn_high = 1'b0;
    expect_at(cyc + 3, 1'b1, 2'b10, 1'b0, "R4 back to normal");
    step(4);

    // hysteresis band: neither above-on nor below-off
    vin_above_on = 1'b0;
    expect_at(cyc + 60, 1'b1, 2'b10, 1'b0, "R2 hysteresis holds power");
    step(62);

    // dip one tick short of the deglitch time
    vin_below_off = 1'b1;
    step((D - 1) * P - 1);
    vin_below_off = 1'b0;
    expect_at(cyc + 6, 1'b1, 2'b10, 1'b0, "R2 short dip survived");
    step(10);

    // full-length dip exits
    c = cyc;
    vin_below_off = 1'b1;
    expect_at(c + 18, 1'b1, 2'b10, 1'b0, "R2 not yet expired");
    expect_at(c + D * P + 6, 1'b0, 2'b00, 1'b1, "R2 deglitch expiry opens switch");
    step(D * P + 10);

    // hot while off: no start
    over_temp = 1'b1; vin_above_on = 1'b1; vin_below_off = 1'b0;
    expect_at(cyc + 10, 1'b0, 2'b00, 1'b1, "R8 no start while hot");
    step(12);
    c = cyc;
    over_temp = 1'b0;
    expect_at(c + 3, 1'b1, 2'b01, 1'b1, "R3 inrush after cooling");
    expect_at(c + 4, 1'b1, 2'b10, 1'b1, "R4 enhanced already");
    expect_at(c + G * P + 8, 1'b1, 2'b10, 1'b0, "R5 released");
    step(G * P + 10);

    // thermal shutdown in power mode
    c = cyc;
    over_temp = 1'b1;
    expect_at(c + 2, 1'b1, 2'b10, 1'b0, "R9 hot not yet seen");
    expect_at(c + 3, 1'b0, 2'b00, 1'b1, "R6 hot opens switch");
    expect_at(c + 19, 1'b0, 2'b00, 1'b1, "R6 stays open while hot");
    step(20);
    c = cyc;
    over_temp = 1'b0;
    expect_at(c + 3, 1'b1, 2'b01, 1'b1, "R7 restart through inrush");
    expect_at(c + (G - 1) * P, 1'b1, 2'b10, 1'b1, "R7 power-good delay restarted");
    expect_at(c + G * P + 8, 1'b1, 2'b10, 1'b0, "R7 power-good released again");
    step(G * P + 10);

    // input lost during thermal shutdown
    over_temp = 1'b1;
    step(5);
    vin_above_on = 1'b0; vin_below_off = 1'b1;
    step(D * P + 20);
    over_temp = 1'b0;
    expect_at(cyc + 10, 1'b0, 2'b00, 1'b1, "R8 expired during hot returns off");
    step(14);

    if (sq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", sq.size());
    end
    finish_run();
  end

endmodule